// File: doc/BRIEF.md
# Reversible Gray Code Counter

This block is a synchronous counter whose state always holds a reflected Gray code word. On every rising clock edge it moves one place along the Gray cycle. A single direction input chooses whether it moves forward or backward. Every step changes exactly one output bit, and this includes the steps that wrap from the last code back to the first. The output can therefore be sampled by logic in another timing domain, or used to drive position-style decoders, without multi-bit glitches.

The width is a parameter and defaults to three bits. With the default width the forward cycle is 000, 001, 011, 010, 110, 111, 101, 100, and then back to 000. The reverse cycle visits the same codes in the opposite order. The state lives in a bank of flip-flops that share one clock. The output comes straight from that register. Every one of the 2^W codes lies on the cycle, so the counter cannot lock up in a stray state.

Top module: `gray_updown_counter`

## Requirements
- R1: While `rst_i` is high at a rising edge, the state becomes all zeros on that edge, whatever `dir_up_i` is.
- R2: With `dir_up_i` = 1, each rising edge advances the state to the next code in the forward cycle. For W=3 that cycle is 000→001→011→010→110→111→101→100→000. In general, step n of the cycle is n XOR (n>>1).
- R3: With `dir_up_i` = 0, each rising edge moves the state to the previous code in the forward cycle. In particular, 000 goes to the code with only the MSB set (100 for W=3), and 001 goes to 000.
- R4: Every step that is not a reset step changes exactly one bit of `code_o`, including both wrap-around steps.
- R5: `dir_up_i` is sampled on the same edge that updates the state. A change of direction governs the very next step and does not alter the current code.
- R6: Every code is on the cycle. From any starting code, 2^W steps in one direction return the counter to that starting code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the state updates on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset to the all-zero code |
| dir_up_i | input | 1 | 1 steps forward along the Gray cycle, 0 steps backward |
| code_o | output | W | Registered Gray code state |

## Verification
The counter is tried with several direction patterns. Long forward runs and long reverse runs check both cycle orders, and they cross each wrap several times. A direction input that toggles on every edge reveals whether a change of direction takes effect on the following step, or is late or early by one edge. A run of 2^W steps from every one of the eight start codes, in each direction, shows that no code is missing from the cycle. A reset applied while the counter is stepping backward shows that reset takes priority over the direction input. Every step is compared with codes computed as n XOR (n>>1), and every step is also checked for a Hamming distance of exactly one.

// File: rtl/gray_cnt_pkg.sv
package gray_cnt_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/gray_to_bin.sv
module gray_to_bin #(
  parameter int W = 3
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  // each binary bit is the XOR of all Gray bits at or above it
  assign bin_o[W-1] = gray_i[W-1];
  generate
    for (genvar i = W-2; i >= 0; i--) begin : g_pref
      assign bin_o[i] = bin_o[i+1] ^ gray_i[i];
    end
  endgenerate
endmodule

// File: rtl/bin_to_gray.sv
module bin_to_gray #(
  parameter int W = 3
) (
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] gray_o
);
  assign gray_o = bin_i ^ (bin_i >> 1);
endmodule

// File: rtl/gray_step.sv
module gray_step #(
  parameter int W = 3
) (
  input  logic [W-1:0] cur_i,
  input  logic         up_i,
  output logic [W-1:0] nxt_o
);
  import gray_cnt_pkg::*;

  logic [W-1:0] cur_bin;
  logic [W-1:0] nxt_bin;

  gray_to_bin #(.W(W)) u_g2b (
    .gray_i (cur_i),
    .bin_o  (cur_bin)
  );

  always_comb begin
    if (dir_e'(up_i) == DIR_UP) nxt_bin = cur_bin + W'(1);
    else                        nxt_bin = cur_bin - W'(1);
  end

  bin_to_gray #(.W(W)) u_b2g (
    .bin_i  (nxt_bin),
    .gray_o (nxt_o)
  );
endmodule

// File: rtl/gray_updown_counter.sv
module gray_updown_counter #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         dir_up_i,
  output logic [W-1:0] code_o
);
  localparam logic [W-1:0] ZERO_CODE = '0;
  localparam logic [W-1:0] ONE_CODE  = W'(1);
  localparam logic [W-1:0] MSB_CODE  = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  gray_step #(.W(W)) u_step (
    .cur_i (state_q),
    .up_i  (dir_up_i),
    .nxt_o (state_d)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) state_q <= ZERO_CODE;
    else       state_q <= state_d;
  end

  assign code_o = state_q;

  // R1
  reset_zero_chk: assert property (@(posedge clk_i) rst_i |=> code_o == ZERO_CODE);

  // R4
  one_bit_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> $countones(code_o ^ $past(code_o)) == 1);

  // R2
  fwd_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (dir_up_i && code_o == ZERO_CODE) |=> code_o == ONE_CODE);

  // R3
  rev_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!dir_up_i && code_o == ZERO_CODE) |=> code_o == MSB_CODE);

  // R3
  rev_to_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!dir_up_i && code_o == ONE_CODE) |=> code_o == ZERO_CODE);
endmodule

// File: tb/gray_updown_counter_tb_top.sv
module gray_updown_counter_tb_top;
  localparam int W = 3;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         dir = 1'b1;
  logic [W-1:0] code;

  int n_chk  = 0;
  int n_fail = 0;
  int idx    = 0;
  bit done   = 1'b0;

  gray_updown_counter #(.W(W)) dut_i (
    .clk_i    (clk),
    .rst_i    (rst),
    .dir_up_i (dir),
    .code_o   (code)
  );

  always #10 clk = ~clk;

  function automatic logic [W-1:0] gray_of(int n);
    logic [W-1:0] b;
    b = W'(n);
    return b ^ (b >> 1);
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: code_o=%b expected %b", req, act, exp);
    end
  endtask

  // one clock edge with the given direction; checks order and one-bit change
  task automatic step(bit up, string req);
    logic [W-1:0] prev;
    prev = code;
    dir  = up;
    @(negedge clk);
    idx = up ? (idx + 1) % N : (idx + N - 1) % N;
    check(req, code, gray_of(idx));
    n_chk++;
    if ($countones(code ^ prev) != 1) begin
      n_fail++;
      $display("FAIL R4: step %b -> %b changed %0d bits, expected 1",
               prev, code, $countones(code ^ prev));
    end
  endtask

  task automatic do_reset(bit d);
    rst = 1'b1;
    dir = d;
    @(negedge clk);
    @(negedge clk);
    idx = 0;
    check("R1", code, '0);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1", code, '0);
    rst = 1'b0;

    // R2: long forward run, crosses the wrap several times
    for (int i = 0; i < 3 * N + 2; i++) step(1'b1, "R2");
    // R3: long reverse run
    for (int i = 0; i < 3 * N + 3; i++) step(1'b0, "R3");
    // R5: alternate direction on every edge
    for (int i = 0; i < 12; i++) step(i[0] == 1'b0, "R5");
    // R5: pairs of each direction
    for (int i = 0; i < 16; i++) step(i[1] == 1'b0, "R5");

    // R1: reset while stepping backward
    for (int i = 0; i < 3; i++) step(1'b0, "R3");
    do_reset(1'b0);
    do_reset(1'b1);

    // R6: every start code, full period each direction returns to start
    for (int s = 0; s < N; s++) begin
      for (int d = 0; d < 2; d++) begin
        logic [W-1:0] start;
        start = code;
        for (int k = 0; k < N; k++) step(d == 0, d == 0 ? "R2" : "R3");
        check("R6", code, start);
      end
      step(1'b1, "R2");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule